// File: doc/BRIEF.md
# Single-Slope Multichannel Conversion Timer

This block is the digital timing back end of a single-slope analog-to-digital converter. One ramp, made by charging an external capacitor from a constant current, is compared against four analog inputs at the same time: two voltage channels, a current-sense channel and an auxiliary channel. The auxiliary channel is fed by a four-way analog selector. The block turns the time at which each comparator trips into a 12-bit code.

A conversion-start pulse, normally the PWM period sync, begins each conversion. The block holds the ramp capacitor in reset for a programmable number of clocks and then releases it. From that point one shared counter runs once per clock from zero up to full scale. Each channel latches the counter on the first clock its comparator is seen high and raises its own valid flag. A channel whose comparator never trips is loaded with full scale when the ramp ends. The auxiliary selector code is taken from the two low bits of a mode register. Code 11 routes the internal reference to the auxiliary comparator so that firmware can calibrate the ramp slope.

Comparator outputs are assumed to be synchronous to `clk_i`. The analog ramp, the current trim and the comparators are outside this block.

Top module: `ssadc_timer`

## Requirements
- R1: While `rst_ni` is low and after its release, `cap_rst_o`=0, `valid_o`=0, `aux_sel_o`=00 and every result field is 0.
- R2: A pulse on `conv_start_i` starts a new conversion at any time, including during a running ramp. On the following clock, all `valid_o` bits are 0 and `cap_rst_o` is 1. If a comparator trips in the same cycle as the start, the start takes precedence and nothing is captured.
- R3: After a start, `cap_rst_o` stays high for exactly max(`hold_cfg_i`,1) clock cycles. The ramp count then begins at 0 and advances by one per clock.
- R4: Channel i captures the ramp count k of the first ramp cycle in which `cmp_i[i]` is sampled high. Ramp cycle k is the k-th clock after `cap_rst_o` falls, counting from 0.
- R5: Once a channel has captured, further comparator transitions on that channel have no effect on its result until the next start.
- R6: A channel whose comparator has not tripped by count 4095 (the 12-bit maximum) is loaded with 0xFFF when the ramp ends. A trip at count 4095 also yields 0xFFF.
- R7: `valid_o[i]` rises in the same cycle that channel i's result is written. It stays high, with the result stable, until the next start.
- R8: `aux_sel_o` takes `aux_sel_cfg_i` at each start and holds it for the whole conversion. The codes are: 00 selects aux input 0, 01 selects aux input 1, 10 selects aux input 2, and 11 selects the internal reference.
- R9: `result_o[12*i +: 12]` holds channel i. Channels 0 and 1 are the voltage inputs, channel 2 is current sense, and channel 3 is the auxiliary channel. Results persist across a start; only the valid flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| conv_start_i | input | 1 | Conversion start pulse (PWM sync) |
| cmp_i | input | 4 | Comparator outputs, high once the ramp exceeds the input |
| aux_sel_cfg_i | input | 2 | Auxiliary selector code from the mode register |
| hold_cfg_i | input | 8 | Capacitor reset hold length in clocks (0 acts as 1) |
| cap_rst_o | output | 1 | Ramp capacitor discharge control |
| aux_sel_o | output | 2 | Latched auxiliary selector lines |
| result_o | output | 48 | Four 12-bit results, channel 0 in the low bits |
| valid_o | output | 4 | Per-channel capture flags |

## Verification
A new conversion start and a channel capture can land on the same clock edge. The bench provokes this by starting a conversion, waiting until the ramp reaches count 5, and then raising channel 0's comparator and pulsing the start in the same cycle. The expected outcome is that the start wins: all flags are low on the next cycle and the capacitor reset is high. Because the comparator is still high, channel 0 then captures count 0 of the fresh ramp, and the scoreboard treats any flag rise from the aborted ramp as a failure.

// File: rtl/ssadc_pkg.sv
package ssadc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_RAMP = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ssadc_seq.sv
module ssadc_seq
  import ssadc_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              cap_rst_o,
  output logic              ramp_o,
  output logic              term_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [HOLD_W-1:0] HOLD_ONE = HOLD_W'(1);

  seq_state_e        state_q;
  logic [HOLD_W-1:0] hold_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_HOLD;
      hold_q  <= HOLD_ONE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          // hold length 0 behaves as 1
          if (hold_q >= hold_i) begin
            state_q <= ST_RAMP;
            cnt_q   <= '0;
          end else begin
            hold_q <= hold_q + HOLD_ONE;
          end
        end
        ST_RAMP: begin
          if (cnt_q == CNT_MAX) state_q <= ST_IDLE;
          else                  cnt_q   <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign cap_rst_o = (state_q == ST_HOLD);
  assign ramp_o    = (state_q == ST_RAMP);
  assign term_o    = ramp_o && (cnt_q == CNT_MAX);
  assign cnt_o     = cnt_q;

  assert_start_resets_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> cap_rst_o && !ramp_o);

  assert_count_steps_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_o && !term_o && !start_i) |=> ramp_o && (cnt_o == CNT_W'($past(cnt_o) + 1'b1)));

  assert_ramp_ends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_o |=> !ramp_o);

  assert_hold_then_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_rst_o && !start_i) |=> cap_rst_o || (ramp_o && cnt_o == '0));
endmodule

// File: rtl/ssadc_chan.sv
module ssadc_chan #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ramp_i,
  input  logic             term_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cmp_i,
  output logic [CNT_W-1:0] res_o,
  output logic             vld_o
);
  logic             vld_q;
  logic [CNT_W-1:0] res_q;

  // at term the count is full scale, so a timeout fill is a plain capture
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (ramp_i && !vld_q && (cmp_i || term_i)) begin
      vld_q <= 1'b1;
      res_q <= cnt_i;
    end
  end

  assign vld_o = vld_q;
  assign res_o = res_q;

  assert_hold_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !clr_i) |=> vld_o && $stable(res_o));

  assert_clear_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !vld_o);

  assert_capture_in_ramp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vld_o) |-> $past(ramp_i));

  assert_fill_at_term_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_i && !clr_i) |=> vld_o);
endmodule

// File: rtl/ssadc_auxsel.sv
module ssadc_auxsel #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] cfg_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (start_i) sel_q <= cfg_i;
  end

  assign sel_o = sel_q;

  assert_sel_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(sel_o));
endmodule

// File: rtl/ssadc_timer.sv
module ssadc_timer #(
  parameter int N_CH   = 4,
  parameter int CNT_W  = 12,
  parameter int HOLD_W = 8,
  parameter int SEL_W  = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  conv_start_i,
  input  logic [N_CH-1:0]       cmp_i,
  input  logic [SEL_W-1:0]      aux_sel_cfg_i,
  input  logic [HOLD_W-1:0]     hold_cfg_i,
  output logic                  cap_rst_o,
  output logic [SEL_W-1:0]      aux_sel_o,
  output logic [N_CH*CNT_W-1:0] result_o,
  output logic [N_CH-1:0]       valid_o
);
  logic             ramp;
  logic             term;
  logic [CNT_W-1:0] cnt;

  ssadc_seq #(.CNT_W(CNT_W), .HOLD_W(HOLD_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (conv_start_i),
    .hold_i   (hold_cfg_i),
    .cap_rst_o(cap_rst_o),
    .ramp_o   (ramp),
    .term_o   (term),
    .cnt_o    (cnt)
  );

  ssadc_auxsel #(.SEL_W(SEL_W)) u_auxsel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(conv_start_i),
    .cfg_i  (aux_sel_cfg_i),
    .sel_o  (aux_sel_o)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ssadc_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (conv_start_i),
      .ramp_i(ramp),
      .term_i(term),
      .cnt_i (cnt),
      .cmp_i (cmp_i[i]),
      .res_o (result_o[i*CNT_W +: CNT_W]),
      .vld_o (valid_o[i])
    );
  end

  assert_no_cap_in_ramp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_rst_o && ramp));

  assert_all_valid_after_term_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term && !conv_start_i) |=> &valid_o);
endmodule

// File: tb/tb_ssadc_timer.sv
module tb_ssadc_timer;
  localparam int N_CH = 4;
  localparam int CW   = 12;
  localparam int MAXC = 4095;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             conv_start_i = 1'b0;
  logic [N_CH-1:0]  cmp_i = '0;
  logic [1:0]       aux_sel_cfg_i = '0;
  logic [7:0]       hold_cfg_i = '0;
  logic             cap_rst_o;
  logic [1:0]       aux_sel_o;
  logic [N_CH*CW-1:0] result_o;
  logic [N_CH-1:0]  valid_o;

  int checks = 0;
  int fails  = 0;
  int exp_q[N_CH][$];
  logic [N_CH-1:0] vprev = '0;

  always #2.5 clk_i = ~clk_i;

  ssadc_timer dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pop expected value on each flag rise
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int c = 0; c < N_CH; c++) begin
        if (valid_o[c] && !vprev[c]) begin
          if (exp_q[c].size() == 0) begin
            chk(1'b0, "R2 unexpected capture", c, -1);
          end else begin
            int e;
            e = exp_q[c].pop_front();
            chk(int'(result_o[c*CW +: CW]) == e, (c == 3) ? "R4/R9 aux ch" : "R4/R6 ch",
                int'(result_o[c*CW +: CW]), e);
          end
        end
      end
      vprev = valid_o;
    end
  end

  function automatic int exp_of(input int t);
    return (t < 0 || t > MAXC) ? MAXC : t;
  endfunction

  task automatic drive_cmp(input int ch, input int heff, input int t);
    if (t >= 0) begin
      repeat (heff + t) @(posedge clk_i);
      @(negedge clk_i) cmp_i[ch] = 1'b1;
      // chatter after capture, R5
      @(negedge clk_i) cmp_i[ch] = 1'b0;
      @(negedge clk_i) cmp_i[ch] = 1'b1;
    end
  endtask

  task automatic start_conv(input int h, input logic [1:0] sel, input bit clr_cmp);
    @(negedge clk_i);
    if (clr_cmp) cmp_i = '0;
    hold_cfg_i    = 8'(h);
    aux_sel_cfg_i = sel;
    conv_start_i  = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) conv_start_i = 1'b0;
  endtask

  // called at the negedge right after the start edge
  task automatic conv_body(input int h, input logic [1:0] sel,
                           input int t0, input int t1, input int t2, input int t3);
    int heff;
    int n;
    heff = (h < 1) ? 1 : h;
    chk(valid_o == '0, "R2 flags cleared", int'(valid_o), 0);
    chk(aux_sel_o == sel, "R8 sel latched", int'(aux_sel_o), int'(sel));
    aux_sel_cfg_i = ~sel;
    n = 0;
    fork
      drive_cmp(0, heff, t0);
      drive_cmp(1, heff, t1);
      drive_cmp(2, heff, t2);
      drive_cmp(3, heff, t3);
      begin
        while (cap_rst_o) begin
          n++;
          @(negedge clk_i);
        end
        chk(n == heff, "R3 hold length", n, heff);
      end
    join
    repeat (heff + MAXC + 1) @(posedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    chk(valid_o == 4'hF, "R7 all valid at end", int'(valid_o), 15);
    chk(aux_sel_o == sel, "R8 sel held during conv", int'(aux_sel_o), int'(sel));
    for (int c = 0; c < N_CH; c++)
      chk(exp_q[c].size() == 0, "R7 capture seen", exp_q[c].size(), 0);
  endtask

  task automatic run_conv(input int h, input logic [1:0] sel,
                          input int t0, input int t1, input int t2, input int t3);
    exp_q[0].push_back(exp_of(t0));
    exp_q[1].push_back(exp_of(t1));
    exp_q[2].push_back(exp_of(t2));
    exp_q[3].push_back(exp_of(t3));
    start_conv(h, sel, 1'b1);
    conv_body(h, sel, t0, t1, t2, t3);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cap_rst_o == 1'b0, "R1 cap reset", int'(cap_rst_o), 0);
    chk(valid_o == '0, "R1 valid", int'(valid_o), 0);
    chk(result_o == '0, "R1 results", int'(result_o[CW-1:0]), 0);
    chk(aux_sel_o == 2'b00, "R1 sel", int'(aux_sel_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(valid_o == '0 && cap_rst_o == 1'b0, "R1 after release", int'(valid_o), 0);

    // staggered trips, channel 3 never trips -> full scale
    run_conv(3, 2'b00, 10, 200, 4000, -1);
    chk(result_o[CW-1:0] == 12'd10, "R9 field position ch0", int'(result_o[CW-1:0]), 10);
    // hold 0 acts as 1, trip at 0 and at the last count, calibration select
    run_conv(0, 2'b11, 0, MAXC, -1, 7);
    // aux select codes 01 and 10
    run_conv(5, 2'b01, 1, 2, 3, 4094);
    run_conv(1, 2'b10, 100, 100, 100, 100);

    // start coincident with a capture: start wins, R2
    start_conv(2, 2'b01, 1'b1);
    repeat (2 + 5) @(posedge clk_i);
    @(negedge clk_i);
    cmp_i[0] = 1'b1;
    conv_start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i) conv_start_i = 1'b0;
    chk(cap_rst_o == 1'b1, "R2 restart cap reset", int'(cap_rst_o), 1);
    chk(result_o[CW-1:0] == 12'd100, "R9 result kept across start",
        int'(result_o[CW-1:0]), 100);
    exp_q[0].push_back(0);  // comparator still high at count 0
    exp_q[1].push_back(50);
    exp_q[2].push_back(60);
    exp_q[3].push_back(MAXC);
    conv_body(2, 2'b01, -1, 50, 60, -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule